// File: doc/BRIEF.md
# Up-Counting Overflow Timer

This block is a general-purpose event timer. A counter advances by one on every clock while it is running. When it steps past the all-ones value it raises an overflow event. Software sets a delay by writing a start value into the counter: to get an event after roughly N counts, it loads all-ones minus N. On overflow the timer does one of two things, chosen by a control bit:

- In one-shot operation it stops at zero.
- In auto-reload operation it reloads from a separate reload register and keeps counting, which gives a periodic tick. A zero reload value with auto-reload gives a free-running counter that can be read at any time.

Setting the run bit takes effect only after a short synchronisation delay. A sticky overflow flag drives the interrupt line when the interrupt-enable bit is set. Software clears the flag by writing a one to it.

Access is through a single-cycle register port. A write is applied on the clock edge where `regWrEn` is high. Reads are combinational from `regAddr`.

Top module: `tmr_up_counter`

## Requirements
- R1: After reset the control, count, reload, interrupt-enable and status registers all read 0, and `irq` is low.
- R2: A write to the count register (address 1) replaces the count at that clock edge, taking priority over an increment. Counting then continues from the written value.
- R3: When a write sets the run bit (control bit 0), the count first increments on the edge SYNC_STAGES+1 edges after the write edge. With the default of 2, that is the third edge.
- R4: A write that clears the run bit stops counting. The count keeps the value it reached at that write edge.
- R5: When the count is all-ones and counting is active, the next edge sets the overflow status bit (status register, address 4, bit 0).
- R6: If the auto-reload bit (control bit 1) is clear at overflow, the count becomes 0, hardware clears the run bit, and the count then holds.
- R7: If the auto-reload bit is set at overflow, the count is loaded from the reload register (address 2), and counting goes on without a gap.
- R8: Writing 1 to status bit 0 clears it, and writing 0 has no effect. An overflow in the same cycle as a clearing write leaves the bit set.
- R9: `irq` is high exactly when the status bit and the interrupt-enable bit (address 3, bit 0) are both set.
- R10: Reads return the register named by `regAddr`, and an unused address reads 0. Writing the reload register does not change the count.
- R11: With the count and reload value both 0 and auto-reload and run both set, the counter counts freely, and its value can be read while it runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 control, 1 count, 2 reload, 3 interrupt enable, 4 status) |
| regWrData | input | CNT_W | Write data |
| regRdData | output | CNT_W | Read data for `regAddr` |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with its defaults: CNT_W of 32 and SYNC_STAGES of 2. Loading start values just below all-ones brings both the one-shot wrap and the auto-reload wrap within a few cycles, even at full width. The two-stage start pipeline makes the start latency observable cycle by cycle against R3. Free-running reads and a count overwrite during counting show that reads and writes do not disturb the running count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_COUNT   = 3'd1,
    REG_RELOAD  = 3'd2,
    REG_IRQEN   = 3'd3,
    REG_IRQSTAT = 3'd4
  } regSel_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_AUTO_BIT = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic loadCount;
    logic loadReload;
    logic autoReload;
  } dpStrobe_t;

endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] reloadVal,
  output logic             wrapHit
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntNext;

  assign wrapHit = stb.countEn && (cntVal == CNT_MAX);

  always_comb begin
    cntNext = cntVal;
    if (stb.loadCount) begin
      cntNext = wrData;
    end else if (stb.countEn) begin
      if (cntVal == CNT_MAX) begin
        cntNext = stb.autoReload ? reloadVal : '0;
      end else begin
        cntNext = cntVal + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal    <= '0;
      reloadVal <= '0;
    end else begin
      cntVal <= cntNext;
      if (stb.loadReload) reloadVal <= wrData;
    end
  end

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [1:0]       wrBits,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             wrapHit,
  output dpStrobe_t        stb,
  output logic [CNT_W-1:0] regRdData,
  output logic             irq,
  output logic             runBit,
  output logic             autoBit,
  output logic             irqStat,
  output logic             irqEn
);

  logic wrCtrl, wrCount, wrReload, wrIrqEn, wrIrqStat;
  logic runSynced;

  assign wrCtrl    = regWrEn && (regAddr == REG_CTRL);
  assign wrCount   = regWrEn && (regAddr == REG_COUNT);
  assign wrReload  = regWrEn && (regAddr == REG_RELOAD);
  assign wrIrqEn   = regWrEn && (regAddr == REG_IRQEN);
  assign wrIrqStat = regWrEn && (regAddr == REG_IRQSTAT);

  // start synchronisation pipeline
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic runQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) runQ <= 1'b0;
        else       runQ <= runBit;
      end
      assign runSynced = runQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] runPipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) runPipe <= '0;
        else       runPipe <= {runPipe[SYNC_STAGES-2:0], runBit};
      end
      assign runSynced = runPipe[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      autoBit <= 1'b0;
      irqEn   <= 1'b0;
      irqStat <= 1'b0;
    end else begin
      if (wrCtrl) begin
        runBit  <= wrBits[CTRL_RUN_BIT];
        autoBit <= wrBits[CTRL_AUTO_BIT];
      end else if (wrapHit && !autoBit) begin
        runBit <= 1'b0;
      end
      if (wrIrqEn) irqEn <= wrBits[0];
      if (wrapHit) begin
        irqStat <= 1'b1;
      end else if (wrIrqStat && wrBits[0]) begin
        irqStat <= 1'b0;
      end
    end
  end

  always_comb begin
    stb.countEn    = runBit && runSynced;
    stb.loadCount  = wrCount;
    stb.loadReload = wrReload;
    stb.autoReload = autoBit;
  end

  assign irq = irqStat && irqEn;

  always_comb begin
    unique case (regAddr)
      REG_CTRL:    regRdData = CNT_W'({autoBit, runBit});
      REG_COUNT:   regRdData = cntVal;
      REG_RELOAD:  regRdData = reloadVal;
      REG_IRQEN:   regRdData = CNT_W'(irqEn);
      REG_IRQSTAT: regRdData = CNT_W'(irqStat);
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: rtl/tmr_up_counter.sv
module tmr_up_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  output logic             irq
);

  dpStrobe_t        stb;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] reloadVal;
  logic             wrapHit;
  logic             runBit, autoBit, irqStat, irqEn;

  tmr_ctrl #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .wrBits    (regWrData[1:0]),
    .cntVal    (cntVal),
    .reloadVal (reloadVal),
    .wrapHit   (wrapHit),
    .stb       (stb),
    .regRdData (regRdData),
    .irq       (irq),
    .runBit    (runBit),
    .autoBit   (autoBit),
    .irqStat   (irqStat),
    .irqEn     (irqEn)
  );

  tmr_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (regWrData),
    .cntVal    (cntVal),
    .reloadVal (reloadVal),
    .wrapHit   (wrapHit)
  );

endmodule

// File: rtl/tmr_up_counter_chk.sv
module tmr_up_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [2:0]       regAddr,
  input logic [CNT_W-1:0] regWrData,
  input logic             irq,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] reloadVal,
  input logic             countEn,
  input logic             runBit,
  input logic             autoBit,
  input logic             irqStat,
  input logic             irqEn
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrCnt, wrCtl;
  assign wrCnt = regWrEn && (regAddr == 3'd1);
  assign wrCtl = regWrEn && (regAddr == 3'd0);

  // R2: a count write lands on the next edge
  a_r2_count_write: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt |=> (cntVal == $past(regWrData)));

  // R3: no increment in the cycle after the run bit rises
  a_r3_start_latency: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runBit) |-> !countEn);

  // R4: stopped counter holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !wrCnt) |=> $stable(cntVal));

  // R5: wrap sets status
  a_r5_status_set: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && cntVal == CNT_MAX) |=> irqStat);

  // R6: one-shot wrap stops at zero
  a_r6_oneshot: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && cntVal == CNT_MAX && !autoBit && !wrCnt && !wrCtl)
      |=> (cntVal == '0 && !runBit));

  // R7: auto-reload wrap loads the reload value
  a_r7_reload: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && cntVal == CNT_MAX && autoBit && !wrCnt)
      |=> (cntVal == $past(reloadVal)));

  // R9: interrupt only with both status and enable
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqStat && irqEn));

endmodule

bind tmr_up_counter tmr_up_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .irq       (irq),
  .cntVal    (cntVal),
  .reloadVal (reloadVal),
  .countEn   (stb.countEn),
  .runBit    (runBit),
  .autoBit   (autoBit),
  .irqStat   (irqStat),
  .irqEn     (irqEn)
);

// File: tb/tb_tmr_up_counter.sv
`timescale 1ns/1ps
module tb_tmr_up_counter;

  localparam int CNT_W = 32;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [2:0]       regAddr = 3'd0;
  logic [CNT_W-1:0] regWrData = '0;
  logic [CNT_W-1:0] regRdData;
  logic             irq;

  always #2.5 clk = ~clk;

  tmr_up_counter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  typedef struct {
    bit               isIrq;
    logic [CNT_W-1:0] exp;
    string            tag;
  } expItem_t;

  expItem_t expQ[$];
  bit probe = 1'b0;
  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (probe && expQ.size() > 0) begin
      expItem_t it;
      logic [CNT_W-1:0] act;
      it = expQ.pop_front();
      act = it.isIrq ? CNT_W'(irq) : regRdData;
      nRun++;
      if (act !== it.exp) begin
        nFail++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic chk(input bit isIrq, input logic [2:0] a,
                     input logic [CNT_W-1:0] e, input string tag);
    expItem_t it;
    @(posedge clk); #1;
    regAddr = a;
    it.isIrq = isIrq; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    probe = 1'b1;
    @(negedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    chk(0, 3'd0, '0, "R1 ctrl");
    chk(0, 3'd1, '0, "R1 count");
    chk(0, 3'd2, '0, "R1 reload");
    chk(0, 3'd3, '0, "R1 irqen");
    chk(0, 3'd4, '0, "R1 status");
    chk(1, 3'd0, '0, "R1 irq");

    // R2 count write while stopped, R4 hold
    wr(3'd1, 32'd100);
    chk(0, 3'd1, 32'd100, "R2 count write");
    chk(0, 3'd1, 32'd100, "R4 stopped hold");

    // R3 start latency
    wr(3'd0, 32'd1);
    chk(0, 3'd1, 32'd100, "R3 edge1");
    chk(0, 3'd1, 32'd100, "R3 edge2");
    chk(0, 3'd1, 32'd101, "R3 edge3");
    chk(0, 3'd1, 32'd102, "R3 edge4");

    // R4 stop holds value reached at write edge
    wr(3'd0, 32'd0);
    chk(0, 3'd1, 32'd104, "R4 stop value");
    chk(0, 3'd1, 32'd104, "R4 stop held");

    // R5/R6 one-shot overflow with N=3
    wr(3'd1, MAXV - 3);
    wr(3'd3, 32'd1);
    wr(3'd0, 32'd1);
    chk(0, 3'd1, MAXV - 3, "R3 oneshot start");
    chk(0, 3'd4, '0, "R5 no early status");
    chk(0, 3'd1, MAXV - 2, "R5 count");
    chk(0, 3'd1, MAXV - 1, "R5 count");
    chk(0, 3'd1, MAXV, "R5 count max");
    chk(0, 3'd4, 32'd1, "R5 status set");
    chk(1, 3'd0, 32'd1, "R9 irq high");
    chk(0, 3'd1, '0, "R6 wrapped to zero");
    chk(0, 3'd0, '0, "R6 run cleared");
    chk(0, 3'd1, '0, "R6 zero held");

    // R8 write-one-to-clear
    wr(3'd4, 32'd0);
    chk(0, 3'd4, 32'd1, "R8 write zero ignored");
    wr(3'd4, 32'd1);
    chk(0, 3'd4, '0, "R8 cleared");
    chk(1, 3'd0, '0, "R9 irq low after clear");

    // R7 auto-reload, R9 gating
    wr(3'd2, MAXV - 1);
    wr(3'd1, MAXV - 1);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd3);
    chk(0, 3'd1, MAXV - 1, "R7 start");
    chk(0, 3'd1, MAXV - 1, "R7 latency");
    chk(0, 3'd1, MAXV, "R7 max");
    chk(0, 3'd1, MAXV - 1, "R7 reloaded");
    chk(0, 3'd4, 32'd1, "R5 status auto");
    chk(1, 3'd0, '0, "R9 irq gated off");
    chk(0, 3'd0, 32'd3, "R7 still running");
    chk(0, 3'd1, MAXV - 1, "R7 second reload");
    wr(3'd3, 32'd1);
    chk(1, 3'd0, 32'd1, "R9 irq enabled");
    wr(3'd0, 32'd0);

    // R11 free running
    wr(3'd2, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd3);
    chk(0, 3'd1, '0, "R11 start");
    idle(8);
    chk(0, 3'd1, 32'd8, "R11 free count");

    // R2 overwrite while running
    wr(3'd1, 32'd1000);
    chk(0, 3'd1, 32'd1001, "R2 running overwrite");
    chk(0, 3'd1, 32'd1002, "R2 continues");

    // R10 reload write leaves count alone, readback, unused address
    wr(3'd2, 32'd55);
    chk(0, 3'd1, 32'd1005, "R10 count undisturbed");
    chk(0, 3'd2, 32'd55, "R10 reload readback");
    chk(0, 3'd7, '0, "R10 unused address");

    idle(2);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule